// File: doc/BRIEF.md
# Frame-Synchronous Coefficient Shadow Buffer

This block sits between a host control port and the two parameter memories of an audio filter engine. The memories are a 384-word table of 16-bit two's-complement coefficients and a 16-word table of 11-bit offsets. When staged mode is selected, each host write is held in a 32-slot staging memory, together with the memory it targets and its word address. The live tables are left untouched until the next frame strobe. At that strobe every staged slot is replayed into the live tables in one back-to-back burst. The filter therefore always sees either the old parameter set or the new one, and never a partly updated mix that could make a recursive section unstable.

When staged mode is off, the buffer is bypassed and every accepted write is forwarded to its table on the next cycle. A host write names a target table and an address. A write may instead continue from the previous one, taking the next address. A continuation that would run past the last word of its table is refused, so a run of writes never wraps back to word 0. While a burst drains, the write port reports not ready, and the host holds its request until the burst ends. A write beyond the staging capacity is dropped and raises a sticky flag.

Top module: `coef_shadow_buf`

## Requirements
- R1: While reset is high and on the first cycle after it, both table write strobes are low; busy, pending, overflow and addr_err are low; and wr_ready is high.
- R2: While batch_mode is 1, an accepted write produces no table write strobe, and pending rises to 1, until a frame strobe arrives.
- R3: A frame_tick sampled at edge E with N staged entries produces N table writes on consecutive cycles, in staging order. Entry j appears on the outputs after edge E+2+j. Afterwards pending and busy return to 0.
- R4: busy is 1 and wr_ready is 0 from the cycle after the strobe until the last entry has been presented. A write held during that time is accepted two edges after the last staged entry is read, and it is staged for the following frame.
- R5: While batch_mode is 0, an accepted write appears on its table port after the same edge that accepted it.
- R6: wr_sel 0 targets the coefficient table and wr_sel 1 targets the offset table. Offset writes carry wr_addr[3:0] and wr_data[10:0]. At most one table strobe is high in any cycle.
- R7: A write with wr_first 0 targets the same table as the previous accepted write, at the previous address plus 1. wr_sel and wr_addr are ignored for such a write.
- R8: A target at or past the end of its table is refused: no strobe and no staging. Such a target is a coefficient address of 384 or more, an offset address of 16 or more, or a continuation after a refused write or after reset. A refused write sets addr_err, which stays set until reset.
- R9: With 32 entries staged, a further staged write is dropped. overflow then sets and stays set until reset, and the next commit writes exactly the 32 kept entries.
- R10: A frame_tick with nothing staged causes no table write and leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| batch_mode | input | 1 | 1 = stage writes until the frame strobe, 0 = forward at once |
| frame_tick | input | 1 | One-cycle strobe at each audio frame boundary |
| wr_valid | input | 1 | Host write request, held until accepted |
| wr_ready | output | 1 | Write accepted on this edge when wr_valid is high |
| wr_first | input | 1 | 1 = use wr_sel/wr_addr, 0 = continue at previous address + 1 |
| wr_sel | input | 1 | Target table: 0 coefficient, 1 offset |
| wr_addr | input | 9 | Word address within the target table |
| wr_data | input | 16 | Write data |
| coef_we | output | 1 | Coefficient table write strobe |
| coef_addr | output | 9 | Coefficient table address |
| coef_wdata | output | 16 | Coefficient table data |
| ofs_we | output | 1 | Offset table write strobe |
| ofs_addr | output | 4 | Offset table address |
| ofs_wdata | output | 11 | Offset table data |
| pending | output | 1 | At least one entry staged |
| busy | output | 1 | Commit burst in progress |
| overflow | output | 1 | Sticky: a staged write was dropped |
| addr_err | output | 1 | Sticky: a write was refused for its address |

## Verification
The bench uses the default parameters: 32 staging slots, 384 coefficient words and 16 offset words. At this size a full buffer plus one extra write can be filled, committed and checked entry by entry. The bench also sweeps every offset address and drives runs up to the top coefficient word and across it, so it can confirm that word 0 is never reached by wrapping. Expected addresses, masked data and cycle numbers are computed in the bench from the strobe and accept cycles.

// File: rtl/shbuf_pkg.sv
package shbuf_pkg;
  typedef enum logic {
    TGT_COEF = 1'b0,
    TGT_OFS  = 1'b1
  } tgt_e;
endpackage

// File: rtl/shbuf_addr_gen.sv
// Resolves the target table/address of each host write and keeps the
// continuation cursor; flags targets outside their table.
module shbuf_addr_gen #(
  parameter int CA_W       = 9,
  parameter int COEF_DEPTH = 384,
  parameter int OFS_DEPTH  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            first,
  input  logic            sel,
  input  logic [CA_W-1:0] addr,
  output logic            t_sel,
  output logic [CA_W-1:0] t_addr,
  output logic            t_ok
);
  localparam logic [CA_W:0] COEF_LIM = (CA_W+1)'(COEF_DEPTH);
  localparam logic [CA_W:0] OFS_LIM  = (CA_W+1)'(OFS_DEPTH);

  logic            cur_ok;
  logic            cur_sel;
  logic [CA_W-1:0] cur_addr;
  logic [CA_W:0]   cand_addr;
  logic            base_ok;
  logic [CA_W:0]   limit;

  always_comb begin
    if (first) begin
      t_sel     = sel;
      cand_addr = {1'b0, addr};
      base_ok   = 1'b1;
    end else begin
      t_sel     = cur_sel;
      cand_addr = {1'b0, cur_addr} + 1'b1;
      base_ok   = cur_ok;
    end
    limit  = t_sel ? OFS_LIM : COEF_LIM;
    t_ok   = base_ok && (cand_addr < limit);
    t_addr = cand_addr[CA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_ok   <= 1'b0;
      cur_sel  <= 1'b0;
      cur_addr <= '0;
    end else if (take) begin
      cur_ok <= t_ok;
      if (t_ok) begin
        cur_sel  <= t_sel;
        cur_addr <= t_addr;
      end
    end
  end
endmodule

// File: rtl/shbuf_stage_mem.sv
// Staging memory: one write port, registered read port (block RAM style).
module shbuf_stage_mem #(
  parameter int ENT_W = 26,
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/shbuf_commit_ctl.sv
// Fill count, overflow detection and the per-frame commit sequencer.
module shbuf_commit_ctl #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stage_req,
  input  logic             frame_tick,
  output logic             stage_we,
  output logic [IDX_W-1:0] stage_idx,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_v,
  output logic             busy,
  output logic             pending,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic             committing;
  logic             full;

  assign full      = (count == FULL);
  assign stage_we  = stage_req && !full;
  assign stage_idx = count[IDX_W-1:0];
  assign rd_en     = committing;
  assign busy      = committing | rd_v;
  assign pending   = (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      committing <= 1'b0;
      rd_idx     <= '0;
      rd_v       <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      rd_v <= committing;
      if (stage_req && full) overflow <= 1'b1;
      if (committing) begin
        if (CNT_W'(rd_idx) == count - 1'b1) begin
          committing <= 1'b0;
          count      <= '0;
          rd_idx     <= '0;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end else begin
        if (stage_we) count <= count + 1'b1;
        if (frame_tick && (pending || stage_we)) begin
          committing <= 1'b1;
          rd_idx     <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/coef_shadow_buf.sv
module coef_shadow_buf
  import shbuf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int BUF_DEPTH  = 32,
  parameter int COEF_DEPTH = 384,
  parameter int OFS_DEPTH  = 16,
  parameter int OFS_W      = 11,
  parameter int CA_W       = $clog2(COEF_DEPTH),
  parameter int OA_W       = $clog2(OFS_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              batch_mode,
  input  logic              frame_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_first,
  input  logic              wr_sel,
  input  logic [CA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              coef_we,
  output logic [CA_W-1:0]   coef_addr,
  output logic [DATA_W-1:0] coef_wdata,
  output logic              ofs_we,
  output logic [OA_W-1:0]   ofs_addr,
  output logic [OFS_W-1:0]  ofs_wdata,
  output logic              pending,
  output logic              busy,
  output logic              overflow,
  output logic              addr_err
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int ENT_W = 1 + CA_W + DATA_W;

  logic             acc;
  logic             t_sel;
  logic [CA_W-1:0]  t_addr;
  logic             t_ok;
  logic             stage_req;
  logic             stage_we;
  logic [IDX_W-1:0] stage_idx;
  logic             rd_en;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_v;
  logic [ENT_W-1:0] wentry;
  logic [ENT_W-1:0] rentry;
  logic [ENT_W-1:0] oentry;
  logic             ovalid;
  tgt_e             otgt;

  assign wr_ready  = !busy;
  assign acc       = wr_valid && wr_ready;
  assign stage_req = acc && batch_mode && t_ok;
  assign wentry    = {t_sel, t_addr, wr_data};

  shbuf_addr_gen #(
    .CA_W(CA_W), .COEF_DEPTH(COEF_DEPTH), .OFS_DEPTH(OFS_DEPTH)
  ) u_addr (
    .clk(clk), .rst(rst), .take(acc), .first(wr_first), .sel(wr_sel),
    .addr(wr_addr), .t_sel(t_sel), .t_addr(t_addr), .t_ok(t_ok)
  );

  shbuf_stage_mem #(
    .ENT_W(ENT_W), .DEPTH(BUF_DEPTH), .IDX_W(IDX_W)
  ) u_mem (
    .clk(clk), .we(stage_we), .waddr(stage_idx), .wdata(wentry),
    .re(rd_en), .raddr(rd_idx), .rdata(rentry)
  );

  shbuf_commit_ctl #(
    .DEPTH(BUF_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .stage_req(stage_req), .frame_tick(frame_tick),
    .stage_we(stage_we), .stage_idx(stage_idx), .rd_en(rd_en),
    .rd_idx(rd_idx), .rd_v(rd_v), .busy(busy), .pending(pending),
    .overflow(overflow)
  );

  // Commit replay and direct forwarding never coincide: direct writes
  // are only accepted while not busy.
  always_comb begin
    if (rd_v) begin
      oentry = rentry;
      ovalid = 1'b1;
    end else begin
      oentry = wentry;
      ovalid = acc && !batch_mode && t_ok;
    end
    otgt = tgt_e'(oentry[ENT_W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_we    <= 1'b0;
      coef_addr  <= '0;
      coef_wdata <= '0;
      ofs_we     <= 1'b0;
      ofs_addr   <= '0;
      ofs_wdata  <= '0;
      addr_err   <= 1'b0;
    end else begin
      coef_we    <= ovalid && (otgt == TGT_COEF);
      ofs_we     <= ovalid && (otgt == TGT_OFS);
      coef_addr  <= oentry[DATA_W +: CA_W];
      coef_wdata <= oentry[DATA_W-1:0];
      ofs_addr   <= oentry[DATA_W +: OA_W];
      ofs_wdata  <= oentry[OFS_W-1:0];
      if (acc && !t_ok) addr_err <= 1'b1;
    end
  end
endmodule

// File: rtl/shbuf_checker.sv
module shbuf_checker (
  input logic clk,
  input logic rst,
  input logic batch_mode,
  input logic frame_tick,
  input logic wr_valid,
  input logic wr_ready,
  input logic coef_we,
  input logic ofs_we,
  input logic pending,
  input logic busy,
  input logic overflow,
  input logic addr_err
);
  // R6: never both tables in one cycle
  p_one_table_r6: assert property (@(posedge clk) disable iff (rst)
    !(coef_we && ofs_we));

  // R2 / R5: a table write comes from a commit or a direct-mode accept
  p_write_source_r5: assert property (@(posedge clk) disable iff (rst)
    (coef_we || ofs_we) |-> ($past(busy) ||
                             $past(wr_valid && wr_ready && !batch_mode)));

  // R3: a burst starts only on a frame strobe
  p_burst_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frame_tick));

  // R3: a finished burst leaves nothing staged
  p_burst_drains_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !pending);

  // R10: empty strobe starts nothing
  p_idle_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !pending && !busy && !wr_valid) |=> !busy);

  // R9: overflow flag is sticky
  p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8: address error flag is sticky
  p_sticky_adr_r8: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> addr_err);
endmodule

bind coef_shadow_buf shbuf_checker u_chk (
  .clk(clk), .rst(rst), .batch_mode(batch_mode), .frame_tick(frame_tick),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .coef_we(coef_we),
  .ofs_we(ofs_we), .pending(pending), .busy(busy), .overflow(overflow),
  .addr_err(addr_err)
);

// File: tb/coef_shadow_buf_test.sv
module coef_shadow_buf_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        batch_mode = 1'b0;
  logic        frame_tick = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_first = 1'b0;
  logic        wr_sel = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        coef_we;
  logic [8:0]  coef_addr;
  logic [15:0] coef_wdata;
  logic        ofs_we;
  logic [3:0]  ofs_addr;
  logic [10:0] ofs_wdata;
  logic        pending, busy, overflow, addr_err;

  coef_shadow_buf uut (
    .clk(clk), .rst(rst), .batch_mode(batch_mode), .frame_tick(frame_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_first(wr_first),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .ofs_we(ofs_we), .ofs_addr(ofs_addr), .ofs_wdata(ofs_wdata),
    .pending(pending), .busy(busy), .overflow(overflow), .addr_err(addr_err)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side copies of the two tables plus a write log
  logic [15:0] cm [384];
  logic [10:0] om [16];
  int lg_sel [256];
  int lg_adr [256];
  int lg_dat [256];
  int lg_cyc [256];
  int lg_n = 0;

  always @(negedge clk) begin
    if (coef_we) begin
      cm[coef_addr] = coef_wdata;
      if (lg_n < 256) begin
        lg_sel[lg_n] = 0; lg_adr[lg_n] = coef_addr;
        lg_dat[lg_n] = coef_wdata; lg_cyc[lg_n] = cyc;
      end
      lg_n = lg_n + 1;
    end
    if (ofs_we) begin
      om[ofs_addr] = ofs_wdata;
      if (lg_n < 256) begin
        lg_sel[lg_n] = 1; lg_adr[lg_n] = ofs_addr;
        lg_dat[lg_n] = ofs_wdata; lg_cyc[lg_n] = cyc;
      end
      lg_n = lg_n + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int acc_cyc = 0;
  int tick_cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic put(input bit f, input bit s, input int a, input int d);
    wr_first = f; wr_sel = s; wr_addr = 9'(a); wr_data = 16'(d);
    wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    acc_cyc = cyc + 1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    tick_cyc = cyc + 1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_valid = 1'b0; frame_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 384; i++) cm[i] = 16'hDEAD;
    for (int i = 0; i < 16; i++) om[i] = 11'h0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 coef_we", coef_we, 0);
    chk("R1 ofs_we", ofs_we, 0);
    chk("R1 busy", busy, 0);
    chk("R1 pending", pending, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 addr_err", addr_err, 0);
    chk("R1 wr_ready", wr_ready, 1);

    // R5 / R7 direct mode
    batch_mode = 1'b0;
    base = lg_n;
    put(1, 0, 0, 16'h5555);
    repeat (2) @(negedge clk);
    chk("R5 direct count", lg_n, base + 1);
    chk("R5 direct addr", lg_adr[base], 0);
    chk("R5 direct data", lg_dat[base], 16'h5555);
    chk("R5 direct latency", lg_cyc[base], acc_cyc);
    base = lg_n;
    put(1, 0, 5, 16'h1234);
    put(0, 1, 77, 16'h2345);
    put(0, 1, 99, 16'h3456);
    repeat (2) @(negedge clk);
    chk("R7 run count", lg_n, base + 3);
    for (int k = 0; k < 3; k++) begin
      chk("R7 run addr", lg_adr[base+k], 5 + k);
      chk("R7 run table", lg_sel[base+k], 0);
    end
    chk("R7 run data", cm[7], 16'h3456);

    // R6 offset sweep over every address, data masked to 11 bits
    base = lg_n;
    for (int i = 0; i < 16; i++)
      put(i == 0, 1, (i == 0) ? 0 : 300, 16'hF800 | ((i * 73 + 5) & 16'hFFFF));
    repeat (2) @(negedge clk);
    chk("R6 offset count", lg_n, base + 16);
    for (int i = 0; i < 16; i++) begin
      chk("R6 offset table", lg_sel[base+i], 1);
      chk("R6 offset data", om[i], (i * 73 + 5) & 11'h7FF);
    end

    // R8 end of table, no wrap
    base = lg_n;
    put(1, 0, 382, 16'h0A0A);
    put(0, 0, 0, 16'h0B0B);
    put(0, 0, 0, 16'h0C0C);
    repeat (2) @(negedge clk);
    chk("R8 writes before end", lg_n, base + 2);
    chk("R8 last word", cm[383], 16'h0B0B);
    chk("R8 word 0 untouched", cm[0], 16'h5555);
    chk("R8 flag set", addr_err, 1);
    put(0, 0, 0, 16'h0D0D);
    put(1, 1, 15, 16'h0111);
    put(0, 1, 0, 16'h0222);
    put(1, 0, 384, 16'h0333);
    put(1, 1, 16, 16'h0444);
    repeat (2) @(negedge clk);
    chk("R8 only ofs 15 written", lg_n, base + 3);
    chk("R8 ofs 15 data", om[15], 11'h111);
    chk("R8 ofs 0 untouched", om[0], 5);
    put(1, 0, 10, 16'h0777);
    repeat (2) @(negedge clk);
    chk("R8 sticky flag", addr_err, 1);
    chk("R8 valid after refusal", cm[10], 16'h0777);
    do_reset();

    // R2 / R3 staged commit
    batch_mode = 1'b1;
    base = lg_n;
    for (int k = 0; k < 5; k++) put(k == 0, 0, 200, k * 1000 + 7);
    for (int k = 0; k < 5; k++) put(k == 0, 1, 4, 16'hFF00 + k);
    repeat (5) @(negedge clk);
    chk("R2 no table writes", lg_n, base);
    chk("R2 pending", pending, 1);
    tick();
    chk("R4 busy in burst", busy, 1);
    chk("R4 not ready in burst", wr_ready, 0);
    repeat (15) @(negedge clk);
    chk("R3 burst count", lg_n, base + 10);
    for (int j = 0; j < 10; j++) begin
      chk("R3 order table", lg_sel[base+j], (j < 5) ? 0 : 1);
      chk("R3 order addr", lg_adr[base+j], (j < 5) ? 200 + j : 4 + j - 5);
      chk("R3 data", lg_dat[base+j],
          (j < 5) ? j * 1000 + 7 : ((16'hFF00 + j - 5) & 11'h7FF));
      chk("R3 cycle", lg_cyc[base+j], tick_cyc + 2 + j);
    end
    chk("R3 pending cleared", pending, 0);
    chk("R3 busy cleared", busy, 0);

    // R4 write held during a burst goes to the next frame
    base = lg_n;
    for (int k = 0; k < 3; k++) put(k == 0, 0, 300, 16'h3000 + k);
    tick();
    put(1, 0, 50, 16'hBEEF);
    chk("R4 held accept cycle", acc_cyc, tick_cyc + 3 + 2);
    repeat (5) @(negedge clk);
    chk("R4 burst excludes held write", lg_n, base + 3);
    chk("R4 held write staged", pending, 1);
    chk("R4 coef 50 untouched", cm[50], 16'hDEAD);
    tick();
    repeat (5) @(negedge clk);
    chk("R4 held write committed", cm[50], 16'hBEEF);

    // R9 overflow
    do_reset();
    batch_mode = 1'b1;
    base = lg_n;
    for (int k = 0; k < 33; k++) put(k == 0, 0, 100, k * 3 + 1);
    chk("R9 overflow flag", overflow, 1);
    chk("R9 pending", pending, 1);
    tick();
    repeat (40) @(negedge clk);
    chk("R9 committed count", lg_n, base + 32);
    for (int k = 0; k < 32; k++)
      chk("R9 kept entry", cm[100 + k], k * 3 + 1);
    chk("R9 dropped entry", cm[132], 16'hDEAD);
    chk("R9 sticky", overflow, 1);

    // R10 empty frame strobe
    base = lg_n;
    tick();
    chk("R10 no burst", busy, 0);
    repeat (5) @(negedge clk);
    chk("R10 no writes", lg_n, base);
    chk("R10 still idle", busy, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule